// File: doc/BRIEF.md
# Masked Pattern Address Generator

This block turns a running transfer index into one memory-test transfer: a target memory address and the data word expected at that address. A pattern store holds 32 pairs of (address, data word). The index first goes through a divider, so it advances once every N transfers, and then through a mask, so the pattern sequence wraps. The selected pair's address is limited to the tested range by a bitwise mask or by a modulo. The expected word is bitwise inverted when the address's row number, masked by a row mask, equals a row select value.

A controller loads the pattern store through a write port. It sets the configuration inputs and pulses `run_start`. It then offers transfer indices on a valid/ready request port and takes results from a valid/ready result port. The control is a two-state machine. `ST_IDLE` moves to `ST_RUN` on the GO transition, which is `run_start` while idle with the result register empty. GO also captures all configuration inputs. `ST_RUN` returns to `ST_IDLE` on the HALT transition (`run_stop`). A result that is still pending when HALT occurs remains held until it is taken.

Top module: `pattern_addr_gen`

## Requirements
- R1: After reset the machine is in `ST_IDLE`, `out_valid` is 0 and `req_ready` is 0.
- R2: GO (`run_start` in `ST_IDLE` with `out_valid` low) makes `req_ready` rise on the next cycle. HALT (`run_stop` in `ST_RUN`) drops `req_ready` on the next cycle. `req_ready` is high only in `ST_RUN` when the result register is empty or is being drained.
- R3: The pattern slot is `(req_index / (idx_div + 1)) & idx_mask`, with `idx_div` holding the divisor minus one. The address and the data word are both read from that slot.
- R4: With modulo mode off (`cfg_modulo` = 0), `out_addr` = stored address AND `cfg_mem_mask`.
- R5: With modulo mode on (`cfg_modulo` = 1), `out_addr` = stored address modulo (`cfg_mem_mask` + 1), so it never exceeds `cfg_mem_mask`.
- R6: The row number is `out_addr >> 3`. `out_data` is the stored word inverted in every bit when (row AND `cfg_inv_div`) == `cfg_inv_sel`, and the stored word unchanged otherwise.
- R7: An accepted request (`req_valid` && `req_ready` at a rising edge) appears on `out_valid`/`out_addr`/`out_data` right after that edge.
- R8: While `out_valid` is high and `out_ready` is low, the result holds unchanged and `req_ready` stays low.
- R9: Configuration inputs are sampled only at GO. Changing them during `ST_RUN` has no effect on results.
- R10: Requests offered in `ST_IDLE` are not accepted and produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_we | input | 1 | Pattern store write enable |
| pat_widx | input | 5 | Pattern slot to write |
| pat_waddr | input | 24 | Address value written to the slot |
| pat_wdata | input | 128 | Data word written to the slot |
| run_start | input | 1 | GO request; captures configuration |
| run_stop | input | 1 | HALT request |
| cfg_modulo | input | 1 | 1: reduce address by modulo, 0: by mask |
| cfg_mem_mask | input | 24 | Address mask, or modulus minus one |
| cfg_idx_mask | input | 5 | Pattern slot mask |
| cfg_idx_div | input | 8 | Index divisor minus one |
| cfg_inv_div | input | 21 | Row mask for inversion |
| cfg_inv_sel | input | 21 | Row select value for inversion |
| req_valid | input | 1 | Transfer index offered |
| req_ready | output | 1 | Transfer index can be taken |
| req_index | input | 16 | Running transfer index |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_addr | output | 24 | Generated memory address |
| out_data | output | 128 | Expected data word |

## Verification
A wrong slot index shows on the port as an address and word from a different pattern entry, in the cycle right after the request is accepted. A stuck state register shows as `req_ready` with the wrong level one cycle after GO or HALT. A configuration register that follows the live inputs produces a wrong address on the first transfer after those inputs change mid-run. A broken hold path changes `out_addr` or `out_data` within one cycle of `out_ready` going low.

// File: rtl/pag_pkg.sv
package pag_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pag_state_e;
endpackage

// File: rtl/pag_pattern_ram.sv
module pag_pattern_ram #(
    parameter int AW    = 24,
    parameter int DW    = 128,
    parameter int DEPTH = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] widx,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] ridx,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [AW-1:0] addr_mem [DEPTH];
    logic [DW-1:0] data_mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (widx == PW'(g))) begin
                addr_mem[g] <= waddr;
                data_mem[g] <= wdata;
            end
        end
    end

    assign raddr = addr_mem[ridx];
    assign rdata = data_mem[ridx];
endmodule

// File: rtl/pag_index_map.sv
module pag_index_map #(
    parameter int IDXW  = 16,
    parameter int DIVW  = 8,
    parameter int DEPTH = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic [IDXW-1:0] xfer_idx,
    input  logic [DIVW-1:0] div_m1,
    input  logic [PW-1:0]   slot_mask,
    output logic [PW-1:0]   slot
);
    logic [DIVW:0]   divisor;
    logic [IDXW-1:0] quot;

    assign divisor = {1'b0, div_m1} + {{DIVW{1'b0}}, 1'b1};
    assign quot    = xfer_idx / IDXW'(divisor);
    assign slot    = quot[PW-1:0] & slot_mask;
endmodule

// File: rtl/pag_addr_reduce.sv
module pag_addr_reduce #(
    parameter int AW = 24
) (
    input  logic          use_mod,
    input  logic [AW-1:0] limit,
    input  logic [AW-1:0] raw,
    output logic [AW-1:0] reduced
);
    logic [AW:0] modulus;
    logic [AW:0] rem;

    assign modulus = {1'b0, limit} + {{AW{1'b0}}, 1'b1};
    assign rem     = {1'b0, raw} % modulus;

    always_comb begin
        if (use_mod) reduced = rem[AW-1:0];
        else         reduced = raw & limit;
    end
endmodule

// File: rtl/pattern_addr_gen.sv
module pattern_addr_gen #(
    parameter int AW        = 24,
    parameter int DW        = 128,
    parameter int DEPTH     = 32,
    parameter int IDXW      = 16,
    parameter int DIVW      = 8,
    parameter int ROW_SHIFT = 3,
    localparam int PW       = $clog2(DEPTH),
    localparam int RW       = AW - ROW_SHIFT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pat_we,
    input  logic [PW-1:0]   pat_widx,
    input  logic [AW-1:0]   pat_waddr,
    input  logic [DW-1:0]   pat_wdata,
    input  logic            run_start,
    input  logic            run_stop,
    input  logic            cfg_modulo,
    input  logic [AW-1:0]   cfg_mem_mask,
    input  logic [PW-1:0]   cfg_idx_mask,
    input  logic [DIVW-1:0] cfg_idx_div,
    input  logic [RW-1:0]   cfg_inv_div,
    input  logic [RW-1:0]   cfg_inv_sel,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [IDXW-1:0] req_index,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [AW-1:0]   out_addr,
    output logic [DW-1:0]   out_data
);
    import pag_pkg::*;

    pag_state_e state, state_nx;

    logic            modulo_q;
    logic [AW-1:0]   mem_mask_q;
    logic [PW-1:0]   idx_mask_q;
    logic [DIVW-1:0] idx_div_q;
    logic [RW-1:0]   inv_div_q;
    logic [RW-1:0]   inv_sel_q;

    logic [PW-1:0]   slot;
    logic [AW-1:0]   slot_addr;
    logic [DW-1:0]   slot_data;
    logic [AW-1:0]   gen_addr;
    logic [DW-1:0]   gen_data;
    logic            row_hit;
    logic            go, accept;

    assign go        = (state == ST_IDLE) && run_start && !out_valid;
    assign req_ready = (state == ST_RUN) && (!out_valid || out_ready);
    assign accept    = req_valid && req_ready;

    pag_index_map #(.IDXW(IDXW), .DIVW(DIVW), .DEPTH(DEPTH)) u_idx (
        .xfer_idx  (req_index),
        .div_m1    (idx_div_q),
        .slot_mask (idx_mask_q),
        .slot      (slot)
    );

    pag_pattern_ram #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (pat_we),
        .widx  (pat_widx),
        .waddr (pat_waddr),
        .wdata (pat_wdata),
        .ridx  (slot),
        .raddr (slot_addr),
        .rdata (slot_data)
    );

    pag_addr_reduce #(.AW(AW)) u_red (
        .use_mod (modulo_q),
        .limit   (mem_mask_q),
        .raw     (slot_addr),
        .reduced (gen_addr)
    );

    assign row_hit  = ((gen_addr[AW-1:ROW_SHIFT] & inv_div_q) == inv_sel_q);
    assign gen_data = slot_data ^ {DW{row_hit}};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: GO (idle -> run), HALT (run -> idle)
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (go)       state_nx = ST_RUN;
            ST_RUN:  if (run_stop) state_nx = ST_IDLE;
        endcase
    end

    // Outputs and configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_addr   <= '0;
            out_data   <= '0;
            modulo_q   <= 1'b0;
            mem_mask_q <= '0;
            idx_mask_q <= '0;
            idx_div_q  <= '0;
            inv_div_q  <= '0;
            inv_sel_q  <= '0;
        end else begin
            if (go) begin
                modulo_q   <= cfg_modulo;
                mem_mask_q <= cfg_mem_mask;
                idx_mask_q <= cfg_idx_mask;
                idx_div_q  <= cfg_idx_div;
                inv_div_q  <= cfg_inv_div;
                inv_sel_q  <= cfg_inv_sel;
            end
            if (accept) begin
                out_valid <= 1'b1;
                out_addr  <= gen_addr;
                out_data  <= gen_data;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pag_checker.sv
module pag_checker #(
    parameter int AW = 24,
    parameter int DW = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          running,
    input logic          req_valid,
    input logic          req_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [AW-1:0] out_addr,
    input logic [DW-1:0] out_data,
    input logic          modulo_q,
    input logic [AW-1:0] mem_mask_q
);
    assert_idle_no_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !req_ready);

    assert_ready_needs_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!out_valid || out_ready));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)));

    assert_one_cycle_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> out_valid);

    assert_no_spurious_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(req_valid && req_ready) && (!out_valid || out_ready)) |=> !out_valid);

    assert_mask_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !modulo_q) |-> ((out_addr & ~mem_mask_q) == '0));

    assert_modulo_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && modulo_q) |-> (out_addr <= mem_mask_q));
endmodule

bind pattern_addr_gen pag_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (state == pag_pkg::ST_RUN),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_addr   (out_addr),
    .out_data   (out_data),
    .modulo_q   (modulo_q),
    .mem_mask_q (mem_mask_q)
);

// File: tb/pattern_addr_gen_tb.sv
`timescale 1ns/1ps
module pattern_addr_gen_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pat_we = 1'b0;
    logic [4:0]   pat_widx = '0;
    logic [23:0]  pat_waddr = '0;
    logic [127:0] pat_wdata = '0;
    logic         run_start = 1'b0, run_stop = 1'b0;
    logic         cfg_modulo = 1'b0;
    logic [23:0]  cfg_mem_mask = '0;
    logic [4:0]   cfg_idx_mask = '0;
    logic [7:0]   cfg_idx_div = '0;
    logic [20:0]  cfg_inv_div = '0, cfg_inv_sel = '0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [15:0]  req_index = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [23:0]  out_addr;
    logic [127:0] out_data;

    int n_checks = 0, n_errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pattern_addr_gen u_dut (.*);

    // Model of the configured run, taken from the requirements
    logic        m_mod;
    logic [23:0] m_mm;
    logic [20:0] m_dm, m_sm;

    function automatic logic [23:0] pa(int k);
        return 24'(24'h012345 + 24'(k) * 24'h0213C9);
    endfunction
    function automatic logic [127:0] pd(int k);
        return {4{32'h5A5A0000 | 32'(k)}};
    endfunction
    function automatic logic [23:0] exp_addr(int k);
        logic [24:0] r;
        r = {1'b0, pa(k)} % ({1'b0, m_mm} + 25'd1);
        return m_mod ? r[23:0] : (pa(k) & m_mm);
    endfunction
    function automatic logic [127:0] exp_data(int k);
        logic [23:0] a;
        a = exp_addr(k);
        return (((a[23:3] & m_dm) == m_sm)) ? ~pd(k) : pd(k);
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic go_run(input logic md, input logic [23:0] mm, input logic [4:0] im,
                          input logic [7:0] dv, input logic [20:0] dm, input logic [20:0] sm);
        @(negedge clk);
        cfg_modulo = md; cfg_mem_mask = mm; cfg_idx_mask = im;
        cfg_idx_div = dv; cfg_inv_div = dm; cfg_inv_sel = sm;
        m_mod = md; m_mm = mm; m_dm = dm; m_sm = sm;
        run_start = 1'b1;
        @(negedge clk);
        run_start = 1'b0;
    endtask

    task automatic halt_run;
        @(negedge clk);
        run_stop = 1'b1;
        @(negedge clk);
        run_stop = 1'b0;
    endtask

    // Issue one transfer with out_ready high; result checked right after the accepting edge
    task automatic xfer(input logic [15:0] idx, input int slot, input string tag);
        @(negedge clk);
        chk({tag, " req_ready"}, 128'(req_ready), 128'(1));
        req_valid = 1'b1; req_index = idx;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " out_valid"}, 128'(out_valid), 128'(1));
        chk({tag, " out_addr"}, 128'(out_addr), 128'(exp_addr(slot)));
        chk({tag, " out_data"}, out_data, exp_data(slot));
    endtask

    localparam int NV = 10;
    localparam logic [15:0] VEC_IDX  [NV] = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd4,
                                              16'd7, 16'd8, 16'd9, 16'd13, 16'd100};
    localparam int          VEC_SLOT [NV] = '{0, 0, 1, 1, 2, 3, 0, 0, 2, 2};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", 128'(out_valid), 128'(0));
        chk("R1 req_ready", 128'(req_ready), 128'(0));

        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            pat_we = 1'b1; pat_widx = 5'(k); pat_waddr = pa(k); pat_wdata = pd(k);
        end
        @(negedge clk);
        pat_we = 1'b0;

        // R10: request in idle is not accepted
        req_valid = 1'b1; req_index = 16'd5;
        repeat (3) @(negedge clk);
        chk("R10 out_valid idle", 128'(out_valid), 128'(0));
        req_valid = 1'b0;

        // R2/R3/R4/R6/R7: divide-by-2, slot mask 3, address mask, invert on row bit 0
        go_run(1'b0, 24'h00FFFF, 5'h03, 8'd1, 21'h1, 21'h1);
        chk("R2 req_ready after GO", 128'(req_ready), 128'(1));
        for (int v = 0; v < NV; v++)
            xfer(VEC_IDX[v], VEC_SLOT[v], $sformatf("R3 R4 R6 R7 vec%0d", v));

        // R8: hold while out_ready low
        @(negedge clk);
        out_ready = 1'b0;
        req_valid = 1'b1; req_index = 16'd4;
        @(negedge clk);
        req_valid = 1'b0;
        req_index = 16'd6;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R8 held valid", 128'(out_valid), 128'(1));
            chk("R8 req_ready low", 128'(req_ready), 128'(0));
            chk("R8 held addr", 128'(out_addr), 128'(exp_addr(2)));
            chk("R8 held data", out_data, exp_data(2));
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk("R8 drained", 128'(out_valid), 128'(0));

        // R2: HALT drops ready
        halt_run;
        chk("R2 req_ready after HALT", 128'(req_ready), 128'(0));

        // R5/R6: modulo 1000, no divide, full slot mask, inversion never matches
        go_run(1'b1, 24'd999, 5'h1F, 8'd0, 21'h0, 21'h1);
        xfer(16'd5,  5,  "R5 R6 idx5");
        xfer(16'd17, 17, "R5 idx17");
        xfer(16'd31, 31, "R5 idx31");
        xfer(16'd40, 8,  "R3 R5 idx40 wrap");

        // R9: live config changes ignored during run
        @(negedge clk);
        cfg_modulo = 1'b0; cfg_mem_mask = 24'hFFFFFF; cfg_inv_div = 21'h0; cfg_inv_sel = 21'h0;
        cfg_idx_div = 8'd3;
        xfer(16'd6, 6, "R9 config frozen");
        halt_run;

        // R6: row mask 0 and select 0 always invert; R3 with divisor 3
        go_run(1'b0, 24'hFFFFFF, 5'h1F, 8'd2, 21'h0, 21'h0);
        xfer(16'd11, 3, "R3 R6 always invert");
        halt_run;

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule